// File: doc/BRIEF.md
# Tightly Coupled SRAM Wrapper

This block gives a processor core a low-latency memory port that behaves like a tightly coupled memory. The port carries a word address, a chip enable, a write enable, four per-byte write strobes and a 32-bit write word. It returns a 32-bit read word that is always actively driven, together with a wait flag. A second port, of the same shape, lets a DMA engine reach the same array.

Inside, each bank holds four byte-wide synchronous RAM slices. The slices have active-low chip select and write enable, and the wrapper derives these from its active-high controls. The upper word-address bits choose one of several banks. A fixed-priority arbiter gives the array to the DMA port first. A core request that loses arbitration, or that arrives while the array is still busy, is captured and held, and the wait flag is raised until that request has completed. A parameter sets the RAM latency. For a latency of N, the array and the granted port stay busy for N-1 cycles after each grant.

Top module: `tcm_sram_wrap`

## Requirements
- R1: An access takes place only for a request presented with its chip enable high at a rising clock edge. A write presented with the chip enable low leaves the array unchanged.
- R2: The address counts 32-bit words. Its top bit(s) select the bank and the remaining bits select the row, so words in every bank can be written and read back independently.
- R3: On a write, strobe bit k updates only bits 8k+7..8k of the addressed word. Lanes whose strobe is clear keep their old value.
- R4: A read returns the whole 32-bit word whatever the strobe bits are.
- R5: A request granted in cycle g delivers read data in cycle g+LAT. The port's wait is high in cycles g+1..g+LAT-1 and low in cycle g+LAT.
- R6: When both ports want a free array in the same cycle, DMA is served first. The core request is held with its address, data, strobes and direction unchanged, the core wait is high, and the core request is served on the next free cycle.
- R7: While a port's wait is high, new requests on that port are ignored and change no memory word.
- R8: The array starts at most one access per cycle and starts none while an earlier access is still inside its latency window.
- R9: After reset, both wait outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_ce | input | 1 | Core request enable |
| core_we | input | 1 | Core write (1) or read (0) |
| core_be | input | 4 | Core byte-lane write strobes, bit k = bits 8k+7..8k |
| core_addr | input | AW | Core word address |
| core_wdata | input | 32 | Core write word |
| core_rdata | output | 32 | Core read word, always driven |
| core_wait | output | 1 | Core stall flag |
| dma_ce | input | 1 | DMA request enable |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_be | input | 4 | DMA byte-lane write strobes |
| dma_addr | input | AW | DMA word address |
| dma_wdata | input | 32 | DMA write word |
| dma_rdata | output | 32 | DMA read word, always driven |
| dma_wait | output | 1 | DMA stall flag |

## Verification
The bound checker checks arbitration on every cycle. It confirms that no more than one grant is issued and that none is issued while the array is busy. It confirms that DMA wins a contested free cycle, that a held core request stays frozen until it is granted, that a stalled port accepts nothing new, and that wait rises after a grant when the latency exceeds one. Data-dependent behaviour can only be shown by the bench's scenarios: lane-selective writes, whole-word reads under arbitrary strobes, bank addressing, writes with the enable low, and the value a deferred core read returns after a colliding DMA write. The bench shows these by comparing every read against a behavioural memory model at the cycle the latency rule predicts.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;

  // Bank index: the word address with the row bits shifted away.
  function automatic int unsigned bank_of(input int unsigned addr, input int unsigned row_w);
    return addr >> row_w;
  endfunction

  // Row inside a bank: the low row_w bits of the word address.
  function automatic int unsigned row_of(input int unsigned addr, input int unsigned row_w);
    return addr & ((32'd1 << row_w) - 32'd1);
  endfunction

  // A lane takes part in an access when reading, or when writing with its strobe set.
  function automatic logic lane_active(input logic we, input logic strobe);
    return !we || strobe;
  endfunction
endpackage

// File: rtl/tcm_byte_ram.sv
module tcm_byte_ram #(
  parameter int unsigned ROW_W = 7
) (
  input  logic             clk,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic [ROW_W-1:0] row,
  input  logic [7:0]       din,
  output logic [7:0]       dout
);
  localparam int unsigned DEPTH = 1 << ROW_W;

  logic [7:0] cells [DEPTH];

  // Synchronous primitive with active-low controls; the output holds between reads.
  always_ff @(posedge clk) begin
    if (!cs_n) begin
      if (!wr_n) cells[row] <= din;
      else       dout       <= cells[row];
    end
  end
endmodule

// File: rtl/tcm_port_chan.sv
module tcm_port_chan #(
  parameter int unsigned AW  = 8,
  parameter int unsigned LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          we,
  input  logic [3:0]    be,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic          grant,
  output logic          want,
  output logic          stall,
  output logic          pend,
  output logic          sel_we,
  output logic [3:0]    sel_be,
  output logic [AW-1:0] sel_addr,
  output logic [31:0]   sel_wdata
);
  localparam int unsigned CNT_W = (LAT > 1) ? $clog2(LAT) : 1;

  logic [CNT_W-1:0] cnt;
  logic             h_we;
  logic [3:0]       h_be;
  logic [AW-1:0]    h_addr;
  logic [31:0]      h_wdata;
  logic             accept;

  assign stall  = pend || (cnt != '0);
  assign accept = ce && !stall;
  assign want   = pend || accept;

  assign sel_we    = pend ? h_we    : we;
  assign sel_be    = pend ? h_be    : be;
  assign sel_addr  = pend ? h_addr  : addr;
  assign sel_wdata = pend ? h_wdata : wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      cnt     <= '0;
      h_we    <= 1'b0;
      h_be    <= '0;
      h_addr  <= '0;
      h_wdata <= '0;
    end else if (grant) begin
      pend <= 1'b0;
      cnt  <= CNT_W'(LAT - 1);
    end else begin
      if (accept) begin
        pend    <= 1'b1;
        h_we    <= we;
        h_be    <= be;
        h_addr  <= addr;
        h_wdata <= wdata;
      end
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/tcm_sram_wrap.sv
module tcm_sram_wrap #(
  parameter int unsigned AW     = 8,
  parameter int unsigned NBANKS = 2,
  parameter int unsigned LAT    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_ce,
  input  logic          core_we,
  input  logic [3:0]    core_be,
  input  logic [AW-1:0] core_addr,
  input  logic [31:0]   core_wdata,
  output logic [31:0]   core_rdata,
  output logic          core_wait,
  input  logic          dma_ce,
  input  logic          dma_we,
  input  logic [3:0]    dma_be,
  input  logic [AW-1:0] dma_addr,
  input  logic [31:0]   dma_wdata,
  output logic [31:0]   dma_rdata,
  output logic          dma_wait
);
  import tcm_pkg::*;

  localparam int unsigned BANK_W = $clog2(NBANKS);
  localparam int unsigned ROW_W  = AW - BANK_W;
  localparam int unsigned CNT_W  = (LAT > 1) ? $clog2(LAT) : 1;

  // Named internal events, observed by the bound checker.
  logic          core_want, dma_want, core_pend, dma_pend;
  logic          gnt_core, gnt_dma, arr_free;
  logic          core_sel_we, dma_sel_we;
  logic [3:0]    core_sel_be, dma_sel_be;
  logic [AW-1:0] core_sel_addr, dma_sel_addr;
  logic [31:0]   core_sel_wdata, dma_sel_wdata;

  tcm_port_chan #(.AW(AW), .LAT(LAT)) u_core (
    .clk(clk), .rst_n(rst_n), .ce(core_ce), .we(core_we), .be(core_be),
    .addr(core_addr), .wdata(core_wdata), .grant(gnt_core),
    .want(core_want), .stall(core_wait), .pend(core_pend),
    .sel_we(core_sel_we), .sel_be(core_sel_be),
    .sel_addr(core_sel_addr), .sel_wdata(core_sel_wdata)
  );

  tcm_port_chan #(.AW(AW), .LAT(LAT)) u_dma (
    .clk(clk), .rst_n(rst_n), .ce(dma_ce), .we(dma_we), .be(dma_be),
    .addr(dma_addr), .wdata(dma_wdata), .grant(gnt_dma),
    .want(dma_want), .stall(dma_wait), .pend(dma_pend),
    .sel_we(dma_sel_we), .sel_be(dma_sel_be),
    .sel_addr(dma_sel_addr), .sel_wdata(dma_sel_wdata)
  );

  // Array occupancy counter and fixed-priority arbitration (DMA first).
  logic [CNT_W-1:0] arr_cnt;
  assign arr_free = (arr_cnt == '0);
  assign gnt_dma  = arr_free && dma_want;
  assign gnt_core = arr_free && core_want && !dma_want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   arr_cnt <= '0;
    else if (gnt_dma || gnt_core) arr_cnt <= CNT_W'(LAT - 1);
    else if (arr_cnt != '0)       arr_cnt <= arr_cnt - 1'b1;
  end

  // Issued operation.
  logic              iss_en, iss_we;
  logic [3:0]        iss_be;
  logic [AW-1:0]     iss_addr;
  logic [31:0]       iss_wdata;
  logic [BANK_W-1:0] iss_bank;
  logic [ROW_W-1:0]  iss_row;

  assign iss_en    = gnt_dma || gnt_core;
  assign iss_we    = gnt_dma ? dma_sel_we    : core_sel_we;
  assign iss_be    = gnt_dma ? dma_sel_be    : core_sel_be;
  assign iss_addr  = gnt_dma ? dma_sel_addr  : core_sel_addr;
  assign iss_wdata = gnt_dma ? dma_sel_wdata : core_sel_wdata;
  assign iss_bank  = BANK_W'(bank_of(32'(iss_addr), ROW_W));
  assign iss_row   = ROW_W'(row_of(32'(iss_addr), ROW_W));

  // Bank of the last read, registered to steer the output mux.
  logic [BANK_W-1:0] rd_bank_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rd_bank_q <= '0;
    else if (iss_en && !iss_we) rd_bank_q <= iss_bank;
  end

  logic [31:0] bank_q [NBANKS];

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic hit;
    assign hit = iss_en && (iss_bank == BANK_W'(b));
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic cs_n, wr_n;
      assign cs_n = !(hit && lane_active(iss_we, iss_be[k]));
      assign wr_n = !iss_we;
      tcm_byte_ram #(.ROW_W(ROW_W)) u_ram (
        .clk(clk), .cs_n(cs_n), .wr_n(wr_n), .row(iss_row),
        .din(iss_wdata[8*k +: 8]), .dout(bank_q[b][8*k +: 8])
      );
    end
  end

  assign core_rdata = bank_q[rd_bank_q];
  assign dma_rdata  = bank_q[rd_bank_q];
endmodule

// File: rtl/tcm_sram_chk.sv
module tcm_sram_chk #(
  parameter int unsigned AW  = 8,
  parameter int unsigned LAT = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_ce,
  input logic          dma_ce,
  input logic          core_wait,
  input logic          dma_wait,
  input logic          core_want,
  input logic          dma_want,
  input logic          core_pend,
  input logic          dma_pend,
  input logic          gnt_core,
  input logic          gnt_dma,
  input logic          arr_free,
  input logic          core_sel_we,
  input logic [3:0]    core_sel_be,
  input logic [AW-1:0] core_sel_addr,
  input logic [31:0]   core_sel_wdata
);
  p_one_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_core, gnt_dma}));

  p_busy_no_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_free |-> !(gnt_core || gnt_dma));

  p_dma_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_want && dma_want && arr_free) |-> (gnt_dma && !gnt_core));

  p_held_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_pend && !gnt_core) |=> (core_pend && $stable(core_sel_addr) &&
      $stable(core_sel_wdata) && $stable(core_sel_be) && $stable(core_sel_we)));

  p_core_needs_ce_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_ce && !core_pend) |-> !gnt_core);

  p_dma_needs_ce_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_ce && !dma_pend) |-> !gnt_dma);

  p_core_wait_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (LAT > 1 && gnt_core) |=> core_wait);

  p_dma_wait_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (LAT > 1 && gnt_dma) |=> dma_wait);

  p_stalled_ignores_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wait && !core_pend) |-> !core_want);
endmodule

bind tcm_sram_wrap tcm_sram_chk #(.AW(AW), .LAT(LAT)) u_chk (.*);

// File: tb/tb_tcm_sram_wrap.sv
module tb_tcm_sram_wrap;
  localparam int AW  = 8;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          core_ce = 0, core_we = 0, dma_ce = 0, dma_we = 0;
  logic [3:0]    core_be = 0, dma_be = 0;
  logic [AW-1:0] core_addr = 0, dma_addr = 0;
  logic [31:0]   core_wdata = 0, dma_wdata = 0;
  logic [31:0]   core_rdata, dma_rdata;
  logic          core_wait, dma_wait;

  always #2 clk = ~clk;   // 250 MHz

  tcm_sram_wrap #(.AW(AW), .NBANKS(2), .LAT(LAT)) dut (.*);

  int compared = 0, mismatched = 0, cyc = 0;
  bit done = 0;
  string cur_tag = "R9";

  // Behavioural reference state.
  logic [31:0] mem [int];
  bit m_cp, m_dp;
  int m_cc, m_dc, m_ac;
  logic m_cwe, m_dwe; logic [3:0] m_cbe, m_dbe;
  int m_caddr, m_daddr; logic [31:0] m_cwd, m_dwd;
  int q_cyc[$]; int q_port[$]; logic [31:0] q_dat[$]; string q_tag[$];

  function automatic bit m_cwait(); return m_cp || m_cc != 0; endfunction
  function automatic bit m_dwait(); return m_dp || m_dc != 0; endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic do_op(input int port, input logic we, input logic [3:0] be, input int a, input logic [31:0] d);
    if (we) begin
      logic [31:0] w;
      w = mem.exists(a) ? mem[a] : 32'h0;
      for (int k = 0; k < 4; k++) if (be[k]) w[8*k +: 8] = d[8*k +: 8];
      mem[a] = w;
    end else begin
      q_cyc.push_back(cyc + LAT); q_port.push_back(port);
      q_dat.push_back(mem.exists(a) ? mem[a] : 32'h0); q_tag.push_back(cur_tag);
    end
  endtask

  task automatic model_step();
    bit cacc, dacc, cw, dw, gd, gc;
    cacc = core_ce && !m_cwait();
    dacc = dma_ce && !m_dwait();
    cw = m_cp || cacc;
    dw = m_dp || dacc;
    gd = (m_ac == 0) && dw;
    gc = (m_ac == 0) && cw && !dw;
    if (gd) begin
      if (m_dp) do_op(1, m_dwe, m_dbe, m_daddr, m_dwd);
      else      do_op(1, dma_we, dma_be, int'(dma_addr), dma_wdata);
      m_dp = 0; m_dc = LAT - 1;
    end else begin
      if (dacc) begin m_dp = 1; m_dwe = dma_we; m_dbe = dma_be; m_daddr = int'(dma_addr); m_dwd = dma_wdata; end
      if (m_dc > 0) m_dc--;
    end
    if (gc) begin
      if (m_cp) do_op(0, m_cwe, m_cbe, m_caddr, m_cwd);
      else      do_op(0, core_we, core_be, int'(core_addr), core_wdata);
      m_cp = 0; m_cc = LAT - 1;
    end else begin
      if (cacc) begin m_cp = 1; m_cwe = core_we; m_cbe = core_be; m_caddr = int'(core_addr); m_cwd = core_wdata; end
      if (m_cc > 0) m_cc--;
    end
    if (gd || gc) m_ac = LAT - 1;
    else if (m_ac > 0) m_ac--;
  endtask

  task automatic tick();
    @(negedge clk);
    check({31'd0, core_wait}, {31'd0, m_cwait()}, rst_n ? "R5" : "R9", "core_wait");
    check({31'd0, dma_wait},  {31'd0, m_dwait()}, rst_n ? "R5" : "R9", "dma_wait");
    while (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
      int p; logic [31:0] e; string t;
      void'(q_cyc.pop_front()); p = q_port.pop_front(); e = q_dat.pop_front(); t = q_tag.pop_front();
      check(p == 0 ? core_rdata : dma_rdata, e, t, p == 0 ? "core_rdata" : "dma_rdata");
    end
    if (rst_n) model_step();
    cyc++;
    @(posedge clk); #1;
  endtask

  task automatic core_req(input logic we, input logic [3:0] be, input int a, input logic [31:0] d);
    while (m_cwait()) tick();
    core_ce = 1; core_we = we; core_be = be; core_addr = AW'(a); core_wdata = d;
    tick();
    core_ce = 0;
  endtask

  task automatic dma_req(input logic we, input logic [3:0] be, input int a, input logic [31:0] d);
    while (m_dwait()) tick();
    dma_ce = 1; dma_we = we; dma_be = be; dma_addr = AW'(a); dma_wdata = d;
    tick();
    dma_ce = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual running, expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R9: idle outputs during and right after reset
    cur_tag = "R9";
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R2: words in both banks through both ports
    cur_tag = "R2";
    core_req(1, 4'hF, 8'h03, 32'h1122_3344);
    core_req(1, 4'hF, 8'h83, 32'hA5A5_0F0F);
    dma_req (1, 4'hF, 8'h40, 32'hDEAD_BEEF);
    dma_req (1, 4'hF, 8'hC0, 32'h0102_0304);
    core_req(1, 4'hF, 8'h4D, 32'h5555_AAAA);
    core_req(0, 4'h0, 8'h03, 32'h0);
    core_req(0, 4'h0, 8'h83, 32'h0);
    dma_req (0, 4'h0, 8'hC0, 32'h0);
    core_req(0, 4'h0, 8'h40, 32'h0);
    idle(LAT + 1);

    // R4: strobes on a read do not narrow the returned word
    cur_tag = "R4";
    core_req(0, 4'b0001, 8'h83, 32'hFFFF_FFFF);
    idle(LAT + 1);

    // R3: strobe 0101 writes lanes 0 and 2 only
    cur_tag = "R3";
    core_req(1, 4'b0101, 8'h03, 32'hFFEE_DDCC);
    core_req(0, 4'h0, 8'h03, 32'h0);
    idle(LAT + 1);

    // R1: write with enable low changes nothing
    cur_tag = "R1";
    core_we = 1; core_be = 4'hF; core_addr = 8'h83; core_wdata = 32'h0;
    tick(); tick();
    core_we = 0;
    core_req(0, 4'h0, 8'h83, 32'h0);
    idle(LAT + 1);

    // R6: collision, DMA write first, deferred core read sees it
    cur_tag = "R6";
    while (m_cwait() || m_dwait() || m_ac != 0) tick();
    core_ce = 1; core_we = 0; core_be = 4'h0; core_addr = 8'h03;
    dma_ce  = 1; dma_we  = 1; dma_be  = 4'hF; dma_addr  = 8'h03; dma_wdata = 32'h9999_8888;
    tick();
    dma_ce = 0;
    // R7: request while core_wait is high is dropped
    cur_tag = "R7";
    core_ce = 1; core_we = 1; core_be = 4'hF; core_addr = 8'h4D; core_wdata = 32'h0;
    tick();
    core_ce = 0; core_we = 0;
    idle(LAT + 2);
    core_req(0, 4'h0, 8'h4D, 32'h0);
    idle(LAT + 1);

    // R6: collision, DMA read sees old word, captured core write lands after
    cur_tag = "R6";
    while (m_cwait() || m_dwait() || m_ac != 0) tick();
    core_ce = 1; core_we = 1; core_be = 4'hF; core_addr = 8'h83; core_wdata = 32'h7777_1234;
    dma_ce  = 1; dma_we  = 0; dma_be  = 4'h0; dma_addr  = 8'h83;
    tick();
    core_ce = 0; dma_ce = 0; core_we = 0;
    idle(LAT + 2);
    core_req(0, 4'h0, 8'h83, 32'h0);
    idle(LAT + 1);

    // R5: back-to-back core reads
    cur_tag = "R5";
    for (int i = 0; i < 4; i++) core_req(0, 4'h0, (i % 2) ? 8'h83 : 8'h03, 32'h0);
    idle(LAT + 1);

    // R8: sustained contention on both ports
    cur_tag = "R8";
    for (int i = 0; i < 24; i++) begin
      core_ce = !m_cwait(); core_we = (i % 3 == 0); core_be = 4'(i + 1);
      core_addr = AW'(8'h10 + i % 4); core_wdata = 32'h1000_0000 * 32'(i) + 32'(i);
      dma_ce = !m_dwait() && (i % 2 == 0); dma_we = (i % 4 == 2); dma_be = 4'hF;
      dma_addr = AW'(8'h10 + (i + 1) % 4); dma_wdata = 32'hC0DE_0000 + 32'(i);
      tick();
    end
    core_ce = 0; dma_ce = 0;
    idle(2 * LAT + 2);
    for (int i = 0; i < 4; i++) core_req(0, 4'h0, 8'h10 + i, 32'h0);
    idle(LAT + 2);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule